// File: doc/BRIEF.md
# Indirect PHY Register Access Port

This block lets software reach a small bank of 8-bit PHY delay registers through one 32-bit host register instead of through direct addressing. Software places a 6-bit PHY address and an 8-bit write value in the control word with both request bits clear. It then writes the same word again with a write or a read request bit set. The block copies the address and data into its own holding registers and drives them onto an internal PHY register bus. When the bank finishes the access, the block raises an acknowledge bit in the control word.

Software polls for the acknowledge and then clears the request bit. The acknowledge falls in response, which completes a four-phase handshake. A read places the stored byte in its own read-data field. That field keeps its value until the next read completes.

The PHY side is a behavioural register bank, 2^ADDR_W entries deep, with a parameter for its access latency. The per-speed-mode input delays sit at addresses 0x00 to 0x08. The clock, high-speed MMC and strobe DLL delays sit at 0x0B, 0x0C and 0x0D. The bank stores any address in its range alike.

Top module: `phy_access_port`

## Requirements
- R1: After reset the control word reads 0x0000_0000, with acknowledge low.
- R2: The control word fields are as follows: PHY address in bits [5:0], write data in bits [15:8], read data in bits [23:16], write request in bit 24, read request in bit 25, acknowledge in bit 26. Bits 7:6 and 31:27 read as 0. Address, write data and both request bits read back as last written.
- R3: A write transfer stores the write-data byte into the PHY register at the given address.
- R4: A read transfer returns the byte stored at the given address in bits [23:16], valid once acknowledge is 1.
- R5: Acknowledge rises only after the PHY access completes: it is first seen high LATENCY+3 clock edges after the edge that captures the request-setting host write.
- R6: Acknowledge stays 1 as long as either request bit is set. It drops to 0 on the clock edge after the edge that captures a write clearing both request bits.
- R7: While acknowledge is 1, a host write that sets a request with a new address and data starts no PHY access.
- R8: Host writes made while a transfer is in flight do not change the address or data of that transfer.
- R9: The read-data field keeps its value until the next read transfer completes; write transfers leave it unchanged.
- R10: The acknowledge bit and the read-data field are read-only; host writes to them are ignored.
- R11: If both request bits are set together, the transfer is a write and the read-data field is not updated.
- R12: Every address of the bank is reachable, including the highest, 0x3F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host write strobe for the control word |
| reg_wdata | input | 32 | Host write value for the control word |
| reg_rdata | output | 32 | Current value of the control word |

## Verification
The hardest cases to reach are host writes that arrive while the block is busy. One kind lands while the PHY access is still in flight (R8). The other lands while acknowledge is held high, waiting for software to drop the request (R7). The bench reaches the first with a second request-setting write one cycle after the first, well inside the latency window. It reaches the second with a different address and data written while polling has already seen acknowledge. Both targets are preloaded with known bytes, so reading them back afterwards shows whether anything leaked through.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
  // Control word field positions (host-visible layout)
  localparam int ADDR_LSB  = 0;
  localparam int WDATA_LSB = 8;
  localparam int RDATA_LSB = 16;
  localparam int WR_BIT    = 24;
  localparam int RD_BIT    = 25;
  localparam int ACK_BIT   = 26;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_ACKED = 2'd2
  } hs_state_e;
endpackage

// File: rtl/phy_reg_bank.sv
module phy_reg_bank #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic              busy;

  // Storage: write port, kept free of reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (req && we) mem[addr] <= wdata;
  end

  // Registered read port, read-first
  always_ff @(posedge clk) begin
    if (req) rdata <= mem[addr];
  end

  // Access latency model
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(LATENCY - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phy_host_reg.sv
module phy_host_reg
  import phy_port_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_value,
  input  logic              ack,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_req_q,
  output logic              rd_req_q,
  output logic [DATA_W-1:0] rd_field_q,
  output logic [WORD_W-1:0] word
);
  logic unused_word;
  assign unused_word = ^wdata;

  // Software-writable fields
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_req_q <= 1'b0;
      rd_req_q <= 1'b0;
    end else if (wr_en) begin
      addr_q   <= wdata[ADDR_LSB +: ADDR_W];
      wdata_q  <= wdata[WDATA_LSB +: DATA_W];
      wr_req_q <= wdata[WR_BIT];
      rd_req_q <= wdata[RD_BIT];
    end
  end

  // Read-only field, loaded by the handshake only
  always_ff @(posedge clk) begin
    if (rst)          rd_field_q <= '0;
    else if (rd_load) rd_field_q <= rd_value;
  end

  always_comb begin
    word = '0;
    word[ADDR_LSB +: ADDR_W]   = addr_q;
    word[WDATA_LSB +: DATA_W]  = wdata_q;
    word[RDATA_LSB +: DATA_W]  = rd_field_q;
    word[WR_BIT]               = wr_req_q;
    word[RD_BIT]               = rd_req_q;
    word[ACK_BIT]              = ack;
  end
endmodule

// File: rtl/phy_handshake_fsm.sv
module phy_handshake_fsm
  import phy_port_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bank_done,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              ack,
  output logic              busy,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_value
);
  hs_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phy_req   <= 1'b0;
      phy_we    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
      ack       <= 1'b0;
    end else begin
      phy_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wr_req || rd_req) begin
            phy_addr  <= addr;
            phy_wdata <= wdata;
            phy_we    <= wr_req;   // write wins when both are set
            phy_req   <= 1'b1;
            state     <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (bank_done) begin
            ack   <= 1'b1;
            state <= ST_ACKED;
          end
        end
        ST_ACKED: begin
          if (!wr_req && !rd_req) begin
            ack   <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state == ST_BUSY);
  assign rd_load  = busy && bank_done && !phy_we;
  assign rd_value = bank_rdata;
endmodule

// File: rtl/phy_access_port.sv
module phy_access_port
  import phy_port_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic [ADDR_W-1:0] sw_addr;
  logic [DATA_W-1:0] sw_wdata;
  logic              wr_req;
  logic              rd_req;
  logic [DATA_W-1:0] rd_field;
  logic              ack;
  logic              hs_busy;
  logic              rd_load;
  logic [DATA_W-1:0] rd_value;
  logic              phy_req;
  logic              phy_we;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              bank_done;
  logic [DATA_W-1:0] bank_rdata;

  phy_host_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host_reg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .wdata      (reg_wdata),
    .rd_load    (rd_load),
    .rd_value   (rd_value),
    .ack        (ack),
    .addr_q     (sw_addr),
    .wdata_q    (sw_wdata),
    .wr_req_q   (wr_req),
    .rd_req_q   (rd_req),
    .rd_field_q (rd_field),
    .word       (reg_rdata)
  );

  phy_handshake_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .addr       (sw_addr),
    .wdata      (sw_wdata),
    .bank_done  (bank_done),
    .bank_rdata (bank_rdata),
    .phy_req    (phy_req),
    .phy_we     (phy_we),
    .phy_addr   (lat_addr),
    .phy_wdata  (lat_wdata),
    .ack        (ack),
    .busy       (hs_busy),
    .rd_load    (rd_load),
    .rd_value   (rd_value)
  );

  phy_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATENCY(LATENCY)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .req   (phy_req),
    .we    (phy_we),
    .addr  (lat_addr),
    .wdata (lat_wdata),
    .done  (bank_done),
    .rdata (bank_rdata)
  );
endmodule

// File: rtl/phy_access_checker.sv
module phy_access_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_req,
  input logic              rd_req,
  input logic              ack,
  input logic [DATA_W-1:0] rd_field,
  input logic              phy_req,
  input logic              hs_busy,
  input logic [ADDR_W-1:0] lat_addr,
  input logic [DATA_W-1:0] lat_wdata,
  input logic              bank_done
);
  assert_ack_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(bank_done));

  assert_ack_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(wr_req || rd_req));

  assert_ack_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> $past(!wr_req && !rd_req));

  assert_no_launch_while_ack_R7: assert property (@(posedge clk) disable iff (rst)
    ack |-> !phy_req);

  assert_latched_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (hs_busy && $past(hs_busy)) |-> ($stable(lat_addr) && $stable(lat_wdata)));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_field) |-> $rose(ack));
endmodule

bind phy_access_port phy_access_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_req    (wr_req),
  .rd_req    (rd_req),
  .ack       (ack),
  .rd_field  (rd_field),
  .phy_req   (phy_req),
  .hs_busy   (hs_busy),
  .lat_addr  (lat_addr),
  .lat_wdata (lat_wdata),
  .bank_done (bank_done)
);

// File: tb/phy_access_port_bench.sv
module phy_access_port_bench;
  localparam int LAT = 3;
  localparam logic [31:0] WR_B = 32'h0100_0000;
  localparam logic [31:0] RD_B = 32'h0200_0000;

  // Vector: {is_write, addr[5:0], data[7:0]}; for reads, data is the expected byte
  localparam logic [14:0] VEC [12] = '{
    {1'b1, 6'h00, 8'h11},
    {1'b1, 6'h08, 8'h5A},
    {1'b1, 6'h0B, 8'hC3},
    {1'b1, 6'h0D, 8'h7E},
    {1'b1, 6'h3F, 8'hFF},
    {1'b1, 6'h0C, 8'h00},
    {1'b0, 6'h0B, 8'hC3},
    {1'b0, 6'h00, 8'h11},
    {1'b0, 6'h3F, 8'hFF},
    {1'b0, 6'h08, 8'h5A},
    {1'b0, 6'h0D, 8'h7E},
    {1'b0, 6'h0C, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  phy_access_port #(.ADDR_W(6), .DATA_W(8), .LATENCY(LAT)) u_phy_access_port (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [31:0] w);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_ack(input logic level);
    for (int i = 0; i < 200 && reg_rdata[26] !== level; i++) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] req_bits, input logic [5:0] a,
                      input logic [7:0] d, output logic [7:0] rd);
    logic [31:0] w;
    w = 32'(a) | (32'(d) << 8);
    host_wr(w);
    host_wr(w | req_bits);
    wait_ack(1'b1);
    rd = reg_rdata[23:16];
    host_wr(w);
    wait_ack(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset word", reg_rdata, 32'h0);

    // R2 layout, R10 read-only fields ignored on write
    host_wr(32'hFCFF_A53C);
    check("R2 field readback", reg_rdata, 32'h0000_A53C);
    host_wr(32'h0);

    // Table walk: R3 writes, R4 reads, R12 top address
    foreach (VEC[i]) begin
      if (VEC[i][14]) begin
        xfer(WR_B, VEC[i][13:8], VEC[i][7:0], rd);
      end else begin
        xfer(RD_B, VEC[i][13:8], 8'h00, rd);
        check("R3 R4 R12 read data", 32'(rd), 32'(VEC[i][7:0]));
      end
    end

    // R5 acknowledge latency
    w = 32'h0000_4201;
    host_wr(w);
    host_wr(w | WR_B);
    repeat (LAT + 2) @(negedge clk);
    check("R5 ack not yet", 32'(reg_rdata[26]), 32'h0);
    @(negedge clk);
    check("R5 ack rises", 32'(reg_rdata[26]), 32'h1);
    // R6 ack held while request set
    repeat (5) @(negedge clk);
    check("R6 ack held", 32'(reg_rdata[26]), 32'h1);
    host_wr(w);
    check("R6 ack before drop", 32'(reg_rdata[26]), 32'h1);
    @(negedge clk);
    check("R6 ack dropped", 32'(reg_rdata[26]), 32'h0);

    // R9 read data held across a write transfer
    xfer(RD_B, 6'h01, 8'h00, rd);
    check("R4 read back 0x01", 32'(rd), 32'h42);
    xfer(WR_B, 6'h02, 8'h99, rd);
    check("R9 rdata held", 32'(reg_rdata[23:16]), 32'h42);

    // R10 ack and rdata not writable
    host_wr(32'h04FF_0000);
    check("R10 read-only fields", reg_rdata, 32'h0042_0000);

    // R7 new request while ack high is ignored
    xfer(WR_B, 6'h06, 8'h33, rd);
    w = 32'h0000_1005;
    host_wr(w);
    host_wr(w | WR_B);
    wait_ack(1'b1);
    host_wr(32'h0000_7706 | WR_B);
    check("R7 ack stays high", 32'(reg_rdata[26]), 32'h1);
    host_wr(32'h0000_7706);
    wait_ack(1'b0);
    xfer(RD_B, 6'h06, 8'h00, rd);
    check("R7 ignored target unchanged", 32'(rd), 32'h33);
    xfer(RD_B, 6'h05, 8'h00, rd);
    check("R7 first write stored", 32'(rd), 32'h10);

    // R8 write during flight keeps latched address and data
    xfer(WR_B, 6'h0A, 8'h44, rd);
    w = 32'h0000_AB09;
    host_wr(w);
    host_wr(w | WR_B);
    host_wr(32'h0000_CD0A | WR_B);
    wait_ack(1'b1);
    host_wr(32'h0000_CD0A);
    wait_ack(1'b0);
    xfer(RD_B, 6'h09, 8'h00, rd);
    check("R8 latched data written", 32'(rd), 32'hAB);
    xfer(RD_B, 6'h0A, 8'h00, rd);
    check("R8 late target unchanged", 32'(rd), 32'h44);

    // R11 both requests: write wins, rdata unchanged
    w = 32'h0000_5C0E;
    host_wr(w);
    host_wr(w | WR_B | RD_B);
    wait_ack(1'b1);
    check("R11 rdata unchanged", 32'(reg_rdata[23:16]), 32'h44);
    host_wr(w);
    wait_ack(1'b0);
    xfer(RD_B, 6'h0E, 8'h00, rd);
    check("R11 write performed", 32'(rd), 32'h5C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule